// File: doc/BRIEF.md
# Host Controller Reset Domain Manager

This block decides which register groups of a USB host controller are wiped by each reset source. Three sources feed it: the synchronous global hardware reset, a software controller-reset bit, and writes to the device power-state field, which arrive with their previous and new values. Five small register banks stand in for the controller's register groups: driver-visible memory-space registers, core-well registers, firmware-programmed registers, configuration registers and suspend-well registers. Each bank is cleared only by the sources that are allowed to touch it.

A software controller reset wipes the driver-visible bank and nothing else. Entry 0 of that bank holds the structural parameters, which firmware loads, so it survives. A power-state write that goes from D3hot to D0 wipes only the core-well bank. This leaves the wake state in the suspend well, the firmware settings and the configuration space as they were. Only the global hardware reset clears everything. Clear strobes are registered, one-cycle pulses, and they are visible on an output vector so that the surrounding controller can follow them.

Top module: `hc_reset_domains`

## Requirements
- R1: One cycle after `hcrst_set` is sampled high, `hcrst_o` reads 1. One cycle after that, `clr_o[0]` is high for exactly one cycle, and the edge that ends this pulse zeroes entries 1 to DEPTH-1 of the memory-space bank.
- R2: Entry 0 of the memory-space bank (the structural parameters) keeps its value through a software controller reset.
- R3: `hcrst_o` returns to 0 on the same edge that ends the `clr_o[0]` pulse.
- R4: A `pwr_wr` with `pwr_old`=2'b11 and `pwr_new`=2'b00 raises `clr_o[1]` for exactly one cycle, starting the cycle after the write, and that pulse zeroes every entry of the core-well bank.
- R5: A D3hot-to-D0 write leaves the memory-space, firmware, configuration and suspend-well banks unchanged.
- R6: Any other power-state write, including 2'b00 to 2'b00 and 2'b11 to 2'b11, produces no strobe and changes no bank.
- R7: A software controller reset leaves the core-well, firmware, configuration and suspend-well banks unchanged. Outside global reset, `clr_o[4:2]` is always 0.
- R8: While `rst` is high, every bank is zeroed, `clr_o` is 0 and `hcrst_o` is 0.
- R9: A write to a bank on the same edge that its clear strobe is applied is dropped. A write to another bank on that edge takes effect.
- R10: `wr_dom` and `rd_dom` use this encoding: 0 memory-space, 1 core-well, 2 firmware, 3 configuration, 4 suspend-well. Codes 5 to 7 write nothing and read 0. `rd_data` is registered and appears one cycle after `rd_dom` and `rd_idx` are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Global hardware reset, synchronous, active high |
| hcrst_set | input | 1 | Software write of 1 to the controller-reset bit |
| hcrst_o | output | 1 | Readback of the controller-reset bit |
| pwr_wr | input | 1 | Power-state field write strobe |
| pwr_old | input | 2 | Power state before the write |
| pwr_new | input | 2 | Power state being written |
| wr_en | input | 1 | Register write enable |
| wr_dom | input | 3 | Bank selected for the write |
| wr_idx | input | IW | Entry index for the write |
| wr_data | input | DW | Write data |
| rd_dom | input | 3 | Bank selected for the read |
| rd_idx | input | IW | Entry index for the read |
| rd_data | output | DW | Registered read data |
| clr_o | output | 5 | Per-bank clear strobes, bit index equals the bank code |

## Verification
The hardest case to reach is a register write that lands on the exact edge where a clear strobe is applied. The strobe is two edges away from the software bit write and one edge away from the power-state write. The stimulus counts those edges and presents writes to the bank being cleared and to a neighbouring bank in that one cycle. Read sweeps afterwards show which write was dropped. A loop over all fifteen non-matching old/new power-state pairs checks that none of them triggers a clear.

// File: rtl/hc_rst_pkg.sv
package hc_rst_pkg;
  localparam int NUM_DOM = 5;
  localparam int DOM_W   = 3;

  localparam logic [DOM_W-1:0] DOM_MEM  = 3'd0;
  localparam logic [DOM_W-1:0] DOM_CORE = 3'd1;
  localparam logic [DOM_W-1:0] DOM_FW   = 3'd2;
  localparam logic [DOM_W-1:0] DOM_CFG  = 3'd3;
  localparam logic [DOM_W-1:0] DOM_SUSP = 3'd4;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/hc_rst_ctrl.sv
module hc_rst_ctrl
  import hc_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hcrst_set,
  input  logic       pwr_wr,
  input  logic [1:0] pwr_old,
  input  logic [1:0] pwr_new,
  output logic       hcrst_bit,
  output logic       clr_mem,
  output logic       clr_core
);
  logic wake_to_d0;

  assign wake_to_d0 = pwr_wr && (pwr_old == PS_D3HOT) && (pwr_new == PS_D0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcrst_bit <= 1'b0;
      clr_mem   <= 1'b0;
      clr_core  <= 1'b0;
    end else begin
      clr_mem  <= hcrst_bit & ~clr_mem;
      clr_core <= wake_to_d0;
      if (hcrst_set)
        hcrst_bit <= 1'b1;
      else if (clr_mem)
        hcrst_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/hc_reg_bank.sv
module hc_reg_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter logic [DEPTH-1:0] KEEP = '0,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        regs[e] <= '0;
      else if (clr) begin
        if (!KEEP[e])
          regs[e] <= '0;
      end else if (we && (widx == IW'(e)))
        regs[e] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int e = 0; e < DEPTH; e++)
      if (ridx == IW'(e))
        rdata = regs[e];
  end
endmodule

// File: rtl/hc_reset_domains.sv
module hc_reset_domains
  import hc_rst_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hcrst_set,
  output logic               hcrst_o,
  input  logic               pwr_wr,
  input  logic [1:0]         pwr_old,
  input  logic [1:0]         pwr_new,
  input  logic               wr_en,
  input  logic [DOM_W-1:0]   wr_dom,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [DOM_W-1:0]   rd_dom,
  input  logic [IW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic [NUM_DOM-1:0] clr_o
);
  logic               clr_mem;
  logic               clr_core;
  logic [NUM_DOM-1:0] bank_clr;
  logic [DW-1:0]      bank_rd [NUM_DOM];
  logic [DW-1:0]      rd_mux;

  hc_rst_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hcrst_set (hcrst_set),
    .pwr_wr    (pwr_wr),
    .pwr_old   (pwr_old),
    .pwr_new   (pwr_new),
    .hcrst_bit (hcrst_o),
    .clr_mem   (clr_mem),
    .clr_core  (clr_core)
  );

  always_comb begin
    bank_clr           = '0;
    bank_clr[DOM_MEM]  = clr_mem;
    bank_clr[DOM_CORE] = clr_core;
  end

  assign clr_o = bank_clr;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_bank
    localparam logic [DEPTH-1:0] KP =
      (g == int'(DOM_MEM)) ? DEPTH'(1) : '0;

    hc_reg_bank #(
      .DW    (DW),
      .DEPTH (DEPTH),
      .KEEP  (KP)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .clr   (bank_clr[g]),
      .we    (wr_en && (wr_dom == DOM_W'(g))),
      .widx  (wr_idx),
      .wdata (wr_data),
      .ridx  (rd_idx),
      .rdata (bank_rd[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int d = 0; d < NUM_DOM; d++)
      if (rd_dom == DOM_W'(d))
        rd_mux = bank_rd[d];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= rd_mux;
  end
endmodule

// File: rtl/hc_reset_domains_chk.sv
module hc_reset_domains_chk
  import hc_rst_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               hcrst_set,
  input logic               hcrst_o,
  input logic               pwr_wr,
  input logic [1:0]         pwr_old,
  input logic [1:0]         pwr_new,
  input logic [NUM_DOM-1:0] clr_o
);
  // R1: memory-space strobe follows the rising reset bit
  a_r1_strobe_follows_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(hcrst_o) |=> clr_o[DOM_MEM]);

  // R1: memory-space strobe lasts one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    clr_o[DOM_MEM] |=> !clr_o[DOM_MEM]);

  // R3: bit self-clears as the strobe ends
  a_r3_self_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_o[DOM_MEM] && !hcrst_set) |=> !hcrst_o);

  // R4: D3hot-to-D0 write raises the core-well strobe
  a_r4_wake_strobe: assert property (@(posedge clk) disable iff (rst)
    (pwr_wr && pwr_old == 2'b11 && pwr_new == 2'b00) |=> clr_o[DOM_CORE]);

  // R6: no other write pattern raises it
  a_r6_no_false_wake: assert property (@(posedge clk) disable iff (rst)
    !(pwr_wr && pwr_old == 2'b11 && pwr_new == 2'b00) |=> !clr_o[DOM_CORE]);

  // R8: global reset quiets strobes and the bit
  a_r8_hw_reset: assert property (@(posedge clk)
    rst |=> (clr_o == '0 && !hcrst_o));
endmodule

bind hc_reset_domains hc_reset_domains_chk u_chk (.*);

// File: tb/test_hc_reset_domains.sv
module test_hc_reset_domains;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hcrst_set = 1'b0;
  logic          hcrst_o;
  logic          pwr_wr = 1'b0;
  logic [1:0]    pwr_old = 2'b00;
  logic [1:0]    pwr_new = 2'b00;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_dom = 3'd0;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_dom = 3'd0;
  logic [IW-1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic [4:0]    clr_o;

  always #4 clk = ~clk;

  hc_reset_domains #(.DW(DW), .DEPTH(DEPTH)) i_hc_reset_domains (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  // behavioural reference
  int m_mem [5][DEPTH];
  int m_bit = 0, m_cm = 0, m_cc = 0, m_rd = 0;

  always @(posedge clk) begin
    int nrd, ncm, nbit, ncc;
    nrd = 0;
    if (rd_dom < 5) nrd = m_mem[rd_dom][rd_idx];
    if (rst) begin
      for (int d = 0; d < 5; d++)
        for (int i = 0; i < DEPTH; i++) m_mem[d][i] = 0;
      m_bit = 0; m_cm = 0; m_cc = 0; m_rd = 0;
    end else begin
      ncm  = (m_bit == 1 && m_cm == 0) ? 1 : 0;
      nbit = hcrst_set ? 1 : (m_cm == 1 ? 0 : m_bit);
      ncc  = (pwr_wr && pwr_old == 2'b11 && pwr_new == 2'b00) ? 1 : 0;
      for (int d = 0; d < 5; d++) begin
        bit wipe;
        wipe = (d == 0 && m_cm == 1) || (d == 1 && m_cc == 1);
        if (wipe) begin
          for (int i = 0; i < DEPTH; i++)
            if (!(d == 0 && i == 0)) m_mem[d][i] = 0;
        end else if (wr_en && wr_dom == 3'(d))
          m_mem[d][wr_idx] = int'(wr_data);
      end
      m_rd = nrd; m_bit = nbit; m_cm = ncm; m_cc = ncc;
    end
    started = 1'b1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1/R4/R7 clr_o vs model", int'(clr_o), m_cm + 2 * m_cc);
      chk("R3 hcrst_o vs model", int'(hcrst_o), m_bit);
      chk("R10 rd_data vs model", int'(rd_data), m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int d, int i, int v);
    wr_en = 1'b1; wr_dom = 3'(d); wr_idx = IW'(i); wr_data = DW'(v);
    step();
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string tag, int d, int i, int exp);
    rd_dom = 3'(d); rd_idx = IW'(i);
    step();
    chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) step();
    chk("R8 clr_o in reset", int'(clr_o), 0);
    chk("R8 hcrst_o in reset", int'(hcrst_o), 0);
    rst = 1'b0;
    step();

    for (int d = 0; d < 5; d++)
      for (int i = 0; i < DEPTH; i++)
        wr(d, i, 16'h1000 * (d + 1) + i + 1);
    wr(5, 1, 16'hEEEE);
    wr(7, 2, 16'hEEEF);
    rdchk("R10 fw readback", 2, 2, 16'h3003);
    rdchk("R10 code 5 reads 0", 5, 1, 0);
    rdchk("R10 code 7 reads 0", 7, 2, 0);

    // software controller reset, with writes on the clearing edge
    hcrst_set = 1'b1;
    step();
    hcrst_set = 1'b0;
    chk("R1 bit set", int'(hcrst_o), 1);
    chk("R1 no strobe yet", int'(clr_o), 0);
    step();
    chk("R1 mem strobe", int'(clr_o), 1);
    wr_en = 1'b1; wr_dom = 3'd0; wr_idx = 2'd2; wr_data = 16'hAAAA;
    step();
    wr_dom = 3'd3; wr_data = 16'hBBBB;
    chk("R1 single pulse", int'(clr_o), 0);
    chk("R3 bit cleared", int'(hcrst_o), 0);
    step();
    wr_en = 1'b0;
    rdchk("R2 struct param kept", 0, 0, 16'h1001);
    rdchk("R1 mem entry cleared", 0, 1, 0);
    rdchk("R9 write dropped on clear", 0, 2, 0);
    rdchk("R1 mem entry 3 cleared", 0, 3, 0);
    rdchk("R7 core kept", 1, 0, 16'h2001);
    rdchk("R7 fw kept", 2, 1, 16'h3002);
    rdchk("R7 susp kept", 4, 3, 16'h5004);
    rdchk("R7 cfg kept", 3, 0, 16'h4001);

    // same-edge write into other bank while mem strobe active
    hcrst_set = 1'b1; step(); hcrst_set = 1'b0; step();
    wr_en = 1'b1; wr_dom = 3'd3; wr_idx = 2'd2; wr_data = 16'hBBBB;
    step();
    wr_en = 1'b0;
    chk("R7 upper strobes idle", int'(clr_o[4:2]), 0);
    rdchk("R9 other bank write lands", 3, 2, 16'hBBBB);

    // non-matching power-state writes
    for (int o = 0; o < 4; o++)
      for (int n = 0; n < 4; n++)
        if (!(o == 3 && n == 0)) begin
          pwr_wr = 1'b1; pwr_old = 2'(o); pwr_new = 2'(n);
          step();
          pwr_wr = 1'b0;
          chk("R6 no strobe", int'(clr_o), 0);
        end
    step();
    chk("R6 no late strobe", int'(clr_o), 0);
    rdchk("R6 core unchanged", 1, 1, 16'h2002);

    // D3hot to D0, with writes on the clearing edge
    wr(0, 1, 16'h1111);
    pwr_wr = 1'b1; pwr_old = 2'b11; pwr_new = 2'b00;
    step();
    pwr_wr = 1'b0;
    chk("R4 core strobe", int'(clr_o), 2);
    wr_en = 1'b1; wr_dom = 3'd1; wr_idx = 2'd3; wr_data = 16'hCCCC;
    step();
    wr_dom = 3'd2; wr_data = 16'hDDDD;
    chk("R4 single pulse", int'(clr_o), 0);
    step();
    wr_en = 1'b0;
    for (int i = 0; i < 3; i++) rdchk("R4 core cleared", 1, i, 0);
    rdchk("R9 core write dropped", 1, 3, 0);
    rdchk("R9 fw write lands", 2, 3, 16'hDDDD);
    rdchk("R5 fw kept", 2, 0, 16'h3001);
    rdchk("R5 susp kept", 4, 0, 16'h5001);
    rdchk("R5 mem kept", 0, 1, 16'h1111);
    rdchk("R5 cfg kept", 3, 0, 16'h4001);

    // global reset
    hcrst_set = 1'b1; step(); hcrst_set = 1'b0;
    rst = 1'b1;
    step(); step();
    chk("R8 bit cleared", int'(hcrst_o), 0);
    chk("R8 strobes low", int'(clr_o), 0);
    rst = 1'b0;
    rdchk("R8 mem zero", 0, 0, 0);
    rdchk("R8 fw zero", 2, 0, 0);
    rdchk("R8 cfg zero", 3, 0, 0);
    rdchk("R8 susp zero", 4, 0, 0);
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule